// File: doc/BRIEF.md
# Sixteen-Bit Timer with Compare Outputs and Input Capture

This block is a 16-bit up-counter for timing, event counting and waveform generation. In timer mode the counter steps once per programmable number of system clocks. In event mode it steps once per chosen edge of an external count pin. Four compare channels watch the counter. Each one can flag an interrupt, change its own output pin, restart the counter or halt it. Three capture pins each copy the counter into a register of their own on a selectable edge, and each can flag an interrupt.

Software reaches the block through a flat word-wide register port. Writes are single-cycle strobes. Reads are combinational from the address. All interrupt causes collect into one sticky flag register. A single request line is the OR of that register.

Top module: `tmr_capmatch`

Register map (word addresses):
- 0 control: bit 0 run, bit 1 event mode, bit 2 count on falling edge in event mode.
- 1 prescale limit.
- 2 counter (a write loads it).
- 3 compare actions: two bits per channel i at [2i+1:2i].
- 4 compare options: bit i interrupt enable, bit 4+i restart-on-hit, bit 8+i halt-on-hit.
- 5 capture setup: edge code for input j at [2j+1:2j], interrupt enable at bit 8+j.
- 6 flags: bits 0..3 compare channels, bits 4..6 capture inputs.
- 7 output pins.
- 8..11 compare values.
- 12..14 capture values (read-only).

## Requirements
- R1: After reset every register reads 0, the counter is 0, all output pins are low and the request line is low.
- R2: In timer mode with run set, the counter advances by one every (prescale limit + 1) clocks. With run clear it holds.
- R3: In event mode the prescaler is bypassed. The counter advances once per synchronized rising edge of the count pin, or per falling edge when control bit 2 is 1.
- R4: A compare hit occurs on a count step while the counter equals that channel's compare value. It sets flag bit i only when option bit i is 1.
- R5: On a hit, channel i drives its output pin according to its action code: 00 unchanged, 01 low, 10 high, 11 inverted. A write to address 7 presets the pins, and a hit with a non-zero action overrides that write in the same cycle.
- R6: With option bit 4+i set, a hit on channel i sends the counter to 0 instead of incrementing it, so the count repeats 0..M.
- R7: With option bit 8+i set, a hit on channel i clears the run bit and the counter holds its value.
- R8: Capture edge codes are 00 off, 01 rising, 10 falling and 11 both. On a selected edge of its synchronized pin, the capture register takes the current counter value. Code 00 never captures.
- R9: A capture sets flag bit 4+j only when setup bit 8+j is 1. Otherwise the capture register still updates.
- R10: Flags stay set until a write of 1 to their bit at address 6. If a flag is set and cleared in the same cycle, it stays set. The request line is high whenever any flag is set.
- R11: Configuration and compare registers read back what was written, limited to their defined bits. A write to the counter address loads the counter and restarts the prescaler. Capture registers ignore writes.
- R12: The counter wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| cnt_in | input | 1 | External count pin (event mode) |
| cap_in | input | 3 | Capture pins |
| match_out | output | 4 | Compare channel output pins |
| irq | output | 1 | OR of all interrupt flags |

## Verification
A capture event can set its interrupt flag in the same clock edge in which software writes 1 to clear that flag. The bench raises a capture pin and counts the two synchronizer stages. It then issues the clear so that the write lands on exactly the edge where the edge detector fires. The flag must read back as set, and the capture register must hold the counter value of that cycle. A second overlap comes from restart-on-hit on one channel while other channels hit in the same run. That case is judged by the pin states and counter value at fixed clock counts after run is set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_CW = 16;
  localparam int TMR_NM = 4;
  localparam int TMR_NC = 3;
  localparam int TMR_AW = 4;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } match_act_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } cap_edge_e;

  localparam logic [3:0] RA_CTRL  = 4'd0;
  localparam logic [3:0] RA_PRESC = 4'd1;
  localparam logic [3:0] RA_COUNT = 4'd2;
  localparam logic [3:0] RA_MACT  = 4'd3;
  localparam logic [3:0] RA_MOPT  = 4'd4;
  localparam logic [3:0] RA_CCFG  = 4'd5;
  localparam logic [3:0] RA_FLAGS = 4'd6;
  localparam logic [3:0] RA_PINS  = 4'd7;
  localparam logic [3:0] RA_MVAL0 = 4'd8;
  localparam logic [3:0] RA_CAP0  = 4'd12;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_EXT  = 1;
  localparam int CTRL_FALL = 2;
  localparam int CCFG_IE_LSB = 8;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] pc_q, pc_d;
  logic         at_lim;

  assign at_lim = (pc_q >= limit);
  assign tick   = en && at_lim;

  always_comb begin
    pc_d = pc_q;
    if (!en || restart) begin
      pc_d = '0;
    end else if (at_lim) begin
      pc_d = '0;
    end else begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic         val_we,
  input  logic [W-1:0] val_wdata,
  input  match_act_e   act,
  input  logic         pin_we,
  input  logic         pin_wval,
  output logic [W-1:0] mval,
  output logic         hit,
  output logic         pin
);
  logic [W-1:0] mval_q, mval_d;
  logic         pin_q, pin_d;

  assign hit  = tick && (count == mval_q);
  assign mval = mval_q;
  assign pin  = pin_q;

  always_comb begin
    mval_d = val_we ? val_wdata : mval_q;
    pin_d  = pin_q;
    if (hit && (act != ACT_NONE)) begin
      case (act)
        ACT_CLR: pin_d = 1'b0;
        ACT_SET: pin_d = 1'b1;
        ACT_TGL: pin_d = ~pin_q;
        default: pin_d = pin_q;
      endcase
    end else if (pin_we) begin
      pin_d = pin_wval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mval_q <= '0;
      pin_q  <= 1'b0;
    end else begin
      mval_q <= mval_d;
      pin_q  <= pin_d;
    end
  end
endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_pin,
  input  cap_edge_e    edge_sel,
  input  logic [W-1:0] count,
  output logic         ev,
  output logic [W-1:0] cap_val
);
  logic         rise, fall;
  logic [W-1:0] cap_q, cap_d;

  tmr_sync_edge u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cap_pin),
    .rise (rise),
    .fall (fall)
  );

  always_comb begin
    case (edge_sel)
      EDGE_RISE: ev = rise;
      EDGE_FALL: ev = fall;
      EDGE_BOTH: ev = rise | fall;
      default:   ev = 1'b0;
    endcase
    cap_d = ev ? count : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else begin
      cap_q <= cap_d;
    end
  end

  assign cap_val = cap_q;
endmodule

// File: rtl/tmr_capmatch.sv
module tmr_capmatch
  import tmr_pkg::*;
#(
  parameter int CNT_W   = TMR_CW,
  parameter int N_MATCH = TMR_NM,
  parameter int N_CAP   = TMR_NC,
  parameter int ADDR_W  = TMR_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata,
  input  logic               cnt_in,
  input  logic [N_CAP-1:0]   cap_in,
  output logic [N_MATCH-1:0] match_out,
  output logic               irq
);
  localparam int NF    = N_MATCH + N_CAP;
  localparam int ACT_W = 2 * N_MATCH;
  localparam int EDG_W = 2 * N_CAP;

  // write strobes
  logic wr_ctrl, wr_presc, wr_count, wr_mact, wr_mopt, wr_ccfg, wr_flags, wr_pins;
  logic [N_MATCH-1:0] wr_mval;

  assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(RA_CTRL));
  assign wr_presc = bus_we && (bus_addr == ADDR_W'(RA_PRESC));
  assign wr_count = bus_we && (bus_addr == ADDR_W'(RA_COUNT));
  assign wr_mact  = bus_we && (bus_addr == ADDR_W'(RA_MACT));
  assign wr_mopt  = bus_we && (bus_addr == ADDR_W'(RA_MOPT));
  assign wr_ccfg  = bus_we && (bus_addr == ADDR_W'(RA_CCFG));
  assign wr_flags = bus_we && (bus_addr == ADDR_W'(RA_FLAGS));
  assign wr_pins  = bus_we && (bus_addr == ADDR_W'(RA_PINS));

  // configuration and state
  logic               run_q, run_d, ext_q, ext_d, fall_q, fall_d;
  logic [CNT_W-1:0]   presc_q, presc_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ACT_W-1:0]   mact_q, mact_d;
  logic [N_MATCH-1:0] mie_q, mie_d, mrst_q, mrst_d, mstop_q, mstop_d;
  logic [EDG_W-1:0]   cedg_q, cedg_d;
  logic [N_CAP-1:0]   cie_q, cie_d;
  logic [NF-1:0]      flags_q, flags_d;

  // datapath nets
  logic               pre_tick, cnt_rise, cnt_fall, ext_tick, tick;
  logic [N_MATCH-1:0] hit;
  logic [N_CAP-1:0]   cap_ev;
  logic               stop_any, rst_any;
  logic [CNT_W-1:0]   mval_w [N_MATCH];
  logic [CNT_W-1:0]   cap_w  [N_CAP];

  // count step sources
  tmr_prescaler #(.W(CNT_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (run_q && !ext_q),
    .restart(wr_count),
    .limit  (presc_q),
    .tick   (pre_tick)
  );

  tmr_sync_edge u_cnt_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cnt_in),
    .rise (cnt_rise),
    .fall (cnt_fall)
  );

  assign ext_tick = fall_q ? cnt_fall : cnt_rise;
  assign tick     = run_q && (ext_q ? ext_tick : pre_tick);

  // compare channels
  for (genvar i = 0; i < N_MATCH; i++) begin : g_match
    assign wr_mval[i] = bus_we && (bus_addr == ADDR_W'(int'(RA_MVAL0) + i));

    tmr_match_unit #(.W(CNT_W)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .count    (cnt_q),
      .val_we   (wr_mval[i]),
      .val_wdata(bus_wdata),
      .act      (match_act_e'(mact_q[2*i +: 2])),
      .pin_we   (wr_pins),
      .pin_wval (bus_wdata[i]),
      .mval     (mval_w[i]),
      .hit      (hit[i]),
      .pin      (match_out[i])
    );
  end

  // capture channels
  for (genvar j = 0; j < N_CAP; j++) begin : g_cap
    tmr_capture_unit #(.W(CNT_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_pin (cap_in[j]),
      .edge_sel(cap_edge_e'(cedg_q[2*j +: 2])),
      .count   (cnt_q),
      .ev      (cap_ev[j]),
      .cap_val (cap_w[j])
    );
  end

  assign stop_any = |(hit & mstop_q);
  assign rst_any  = |(hit & mrst_q);

  // next state
  always_comb begin
    run_d  = run_q;
    ext_d  = ext_q;
    fall_d = fall_q;
    if (wr_ctrl) begin
      run_d  = bus_wdata[CTRL_RUN];
      ext_d  = bus_wdata[CTRL_EXT];
      fall_d = bus_wdata[CTRL_FALL];
    end else if (stop_any) begin
      run_d = 1'b0;
    end

    presc_d = wr_presc ? bus_wdata : presc_q;
    mact_d  = wr_mact ? bus_wdata[ACT_W-1:0] : mact_q;

    mie_d   = mie_q;
    mrst_d  = mrst_q;
    mstop_d = mstop_q;
    if (wr_mopt) begin
      mie_d   = bus_wdata[N_MATCH-1:0];
      mrst_d  = bus_wdata[2*N_MATCH-1:N_MATCH];
      mstop_d = bus_wdata[3*N_MATCH-1:2*N_MATCH];
    end

    cedg_d = cedg_q;
    cie_d  = cie_q;
    if (wr_ccfg) begin
      cedg_d = bus_wdata[EDG_W-1:0];
      cie_d  = bus_wdata[CCFG_IE_LSB +: N_CAP];
    end

    cnt_d = cnt_q;
    if (wr_count) begin
      cnt_d = bus_wdata;
    end else if (tick) begin
      if (rst_any) begin
        cnt_d = '0;
      end else if (!stop_any) begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    flags_d = (flags_q & ~(wr_flags ? bus_wdata[NF-1:0] : {NF{1'b0}}))
            | {cap_ev & cie_q, hit & mie_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ext_q   <= 1'b0;
      fall_q  <= 1'b0;
      presc_q <= '0;
      cnt_q   <= '0;
      mact_q  <= '0;
      mie_q   <= '0;
      mrst_q  <= '0;
      mstop_q <= '0;
      cedg_q  <= '0;
      cie_q   <= '0;
      flags_q <= '0;
    end else begin
      run_q   <= run_d;
      ext_q   <= ext_d;
      fall_q  <= fall_d;
      presc_q <= presc_d;
      cnt_q   <= cnt_d;
      mact_q  <= mact_d;
      mie_q   <= mie_d;
      mrst_q  <= mrst_d;
      mstop_q <= mstop_d;
      cedg_q  <= cedg_d;
      cie_q   <= cie_d;
      flags_q <= flags_d;
    end
  end

  assign irq = |flags_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(RA_CTRL):  bus_rdata = CNT_W'({fall_q, ext_q, run_q});
      ADDR_W'(RA_PRESC): bus_rdata = presc_q;
      ADDR_W'(RA_COUNT): bus_rdata = cnt_q;
      ADDR_W'(RA_MACT):  bus_rdata = CNT_W'(mact_q);
      ADDR_W'(RA_MOPT):  bus_rdata = CNT_W'({mstop_q, mrst_q, mie_q});
      ADDR_W'(RA_CCFG): begin
        bus_rdata[EDG_W-1:0]            = cedg_q;
        bus_rdata[CCFG_IE_LSB +: N_CAP] = cie_q;
      end
      ADDR_W'(RA_FLAGS): bus_rdata = CNT_W'(flags_q);
      ADDR_W'(RA_PINS):  bus_rdata = CNT_W'(match_out);
      default: bus_rdata = '0;
    endcase
    for (int i = 0; i < N_MATCH; i++) begin
      if (bus_addr == ADDR_W'(int'(RA_MVAL0) + i)) bus_rdata = mval_w[i];
    end
    for (int j = 0; j < N_CAP; j++) begin
      if (bus_addr == ADDR_W'(int'(RA_CAP0) + j)) bus_rdata = cap_w[j];
    end
  end
endmodule

// File: rtl/tmr_capmatch_sva.sv
module tmr_capmatch_sva
  import tmr_pkg::*;
#(
  parameter int CNT_W   = TMR_CW,
  parameter int N_MATCH = TMR_NM,
  parameter int ADDR_W  = TMR_AW
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [CNT_W-1:0]   bus_wdata,
  input logic               irq,
  input logic [N_MATCH-1:0] match_out,
  input logic               run_q,
  input logic               ext_q,
  input logic               tick,
  input logic               stop_any,
  input logic [CNT_W-1:0]   cnt_q,
  input logic [CNT_W-1:0]   cap0
);
  logic w_cnt, w_ctrl, w_flags, w_pins;
  assign w_cnt   = bus_we && (bus_addr == ADDR_W'(RA_COUNT));
  assign w_ctrl  = bus_we && (bus_addr == ADDR_W'(RA_CTRL));
  assign w_flags = bus_we && (bus_addr == ADDR_W'(RA_FLAGS));
  assign w_pins  = bus_we && (bus_addr == ADDR_W'(RA_PINS));

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    w_cnt |=> (cnt_q == $past(bus_wdata))); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !w_cnt) |=> $stable(cnt_q)); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !ext_q && !w_cnt) |=>
      ((cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) || (cnt_q == '0))); // R2

  AST_HALT_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_any && !w_ctrl) |=> !run_q); // R7

  AST_FLAG_CLR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(w_flags)); // R10

  AST_CAP_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap0 != $past(cap0)) |-> (cap0 == $past(cnt_q))); // R8

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(match_out) |-> $past(tick || w_pins)); // R5
endmodule

bind tmr_capmatch tmr_capmatch_sva #(
  .CNT_W  (CNT_W),
  .N_MATCH(N_MATCH),
  .ADDR_W (ADDR_W)
) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq      (irq),
  .match_out(match_out),
  .run_q    (run_q),
  .ext_q    (ext_q),
  .tick     (tick),
  .stop_any (stop_any),
  .cnt_q    (cnt_q),
  .cap0     (cap_w[0])
);

// File: tb/tmr_capmatch_tb.sv
module tmr_capmatch_tb;
  localparam int CLK_P = 10;
  localparam int NV = 42;

  // {we, addr[3:0], data[15:0], req[3:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 4'd0,  16'h0000, 4'd1}, {1'b0, 4'd1,  16'h0000, 4'd1}, {1'b0, 4'd2,  16'h0000, 4'd1},
    {1'b0, 4'd3,  16'h0000, 4'd1}, {1'b0, 4'd4,  16'h0000, 4'd1}, {1'b0, 4'd5,  16'h0000, 4'd1},
    {1'b0, 4'd6,  16'h0000, 4'd1}, {1'b0, 4'd7,  16'h0000, 4'd1}, {1'b0, 4'd8,  16'h0000, 4'd1},
    {1'b0, 4'd9,  16'h0000, 4'd1}, {1'b0, 4'd10, 16'h0000, 4'd1}, {1'b0, 4'd11, 16'h0000, 4'd1},
    {1'b0, 4'd12, 16'h0000, 4'd1}, {1'b0, 4'd13, 16'h0000, 4'd1}, {1'b0, 4'd14, 16'h0000, 4'd1},
    // readback, R11
    {1'b1, 4'd1,  16'h0005, 4'd11}, {1'b0, 4'd1,  16'h0005, 4'd11},
    {1'b1, 4'd8,  16'h1234, 4'd11}, {1'b0, 4'd8,  16'h1234, 4'd11},
    {1'b1, 4'd11, 16'hBEEF, 4'd11}, {1'b0, 4'd11, 16'hBEEF, 4'd11},
    {1'b1, 4'd3,  16'hFFE4, 4'd11}, {1'b0, 4'd3,  16'h00E4, 4'd11},
    {1'b1, 4'd4,  16'hFFFF, 4'd11}, {1'b0, 4'd4,  16'h0FFF, 4'd11},
    {1'b1, 4'd5,  16'hFFFF, 4'd11}, {1'b0, 4'd5,  16'h073F, 4'd11},
    {1'b1, 4'd0,  16'hFFFE, 4'd11}, {1'b0, 4'd0,  16'h0006, 4'd11},
    {1'b1, 4'd7,  16'h000A, 4'd5},  {1'b0, 4'd7,  16'h000A, 4'd5},
    {1'b1, 4'd12, 16'h5555, 4'd11}, {1'b0, 4'd12, 16'h0000, 4'd11},
    // restore zeros
    {1'b1, 4'd1,  16'h0000, 4'd11}, {1'b1, 4'd8,  16'h0000, 4'd11},
    {1'b1, 4'd11, 16'h0000, 4'd11}, {1'b1, 4'd3,  16'h0000, 4'd11},
    {1'b1, 4'd4,  16'h0000, 4'd11}, {1'b1, 4'd5,  16'h0000, 4'd11},
    {1'b1, 4'd0,  16'h0000, 4'd11}, {1'b1, 4'd7,  16'h0000, 4'd11},
    {1'b0, 4'd7,  16'h0000, 4'd5}
  };

  logic        clk, rst_n, bus_we, cnt_in, irq;
  logic [3:0]  bus_addr, match_out;
  logic [15:0] bus_wdata, bus_rdata;
  logic [2:0]  cap_in;
  int nvec, nerr;

  tmr_capmatch u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_in(cnt_in),
    .cap_in(cap_in), .match_out(match_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cnt(input int n);
    for (int p = 0; p < n; p++) begin
      cnt_in = 1'b1; wait_n(2);
      cnt_in = 1'b0; wait_n(2);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    nvec = 0; nerr = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    cnt_in = 1'b0; cap_in = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1: pins and request line after reset
    check("R1 pins", {12'd0, match_out}, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);

    // table walk: reset values and register map
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][24]) begin
        wr(VEC[k][23:20], VEC[k][19:4]);
      end else begin
        rd(VEC[k][23:20], v);
        check($sformatf("R%0d table %0d", VEC[k][3:0], k), v, VEC[k][19:4]);
      end
    end

    // R2: prescale limit 2 -> one step per 3 clocks
    wr(4'd1, 16'd2); wr(4'd2, 16'd0); wr(4'd0, 16'h0001);
    wait_n(9);
    rdchk("R2 count after 9 clocks", 4'd2, 16'd3);
    wr(4'd0, 16'h0000);
    rdchk("R2 count after stop", 4'd2, 16'd3);
    wait_n(4);
    rdchk("R2 hold while idle", 4'd2, 16'd3);

    // R12: wrap
    wr(4'd1, 16'd0); wr(4'd2, 16'hFFFE); wr(4'd0, 16'h0001);
    wait_n(2);
    rdchk("R12 wrap to zero", 4'd2, 16'h0000);
    wr(4'd0, 16'h0000);

    // R4 R5 R6: three channels, channel 1 restarts the count
    wr(4'd2, 16'd0);
    wr(4'd8, 16'd3); wr(4'd9, 16'd5); wr(4'd10, 16'd2);
    wr(4'd3, 16'h001B);          // ch0 toggle, ch1 set, ch2 clear, ch3 none
    wr(4'd7, 16'h0004);          // preset ch2 high
    wr(4'd4, 16'h0027);          // irq en ch0..2, restart on ch1
    rdchk("R5 pin preset", 4'd7, 16'h0004);
    wr(4'd0, 16'h0001);
    wait_n(7);
    rdchk("R5 pins after first pass", 4'd7, 16'h0003);
    rdchk("R6 count restarted", 4'd2, 16'd1);
    rdchk("R4 flags of hit channels", 4'd6, 16'h0007);
    check("R10 irq high", {15'd0, irq}, 16'h0001);
    wait_n(3);
    rdchk("R5 toggle on second pass", 4'd7, 16'h0002);
    rdchk("R6 count in second period", 4'd2, 16'd4);
    wr(4'd0, 16'h0000);

    // R10: write-one-to-clear
    wr(4'd6, 16'h0001);
    rdchk("R10 partial clear", 4'd6, 16'h0006);
    check("R10 irq still high", {15'd0, irq}, 16'h0001);
    wr(4'd6, 16'h0006);
    rdchk("R10 all clear", 4'd6, 16'h0000);
    check("R10 irq low", {15'd0, irq}, 16'h0000);

    // R7: halt on channel 3 hit
    wr(4'd3, 16'h0000); wr(4'd4, 16'h0808); wr(4'd11, 16'd4);
    wr(4'd2, 16'd0); wr(4'd0, 16'h0001);
    wait_n(8);
    rdchk("R7 count held", 4'd2, 16'd4);
    rdchk("R7 run cleared", 4'd0, 16'h0000);
    rdchk("R7 flag ch3", 4'd6, 16'h0008);
    wr(4'd6, 16'h007F); wr(4'd4, 16'h0000);

    // R8 R9: edge codes, cap1 interrupt disabled
    wr(4'd2, 16'h0AAA); wr(4'd5, 16'h0539);
    cap_in = 3'b111; wait_n(4);
    rdchk("R8 rise captured", 4'd12, 16'h0AAA);
    rdchk("R8 fall ignores rise", 4'd13, 16'h0000);
    rdchk("R8 both on rise", 4'd14, 16'h0AAA);
    rdchk("R9 flags on rise", 4'd6, 16'h0050);
    wr(4'd2, 16'h0BBB);
    cap_in = 3'b000; wait_n(4);
    rdchk("R8 rise ignores fall", 4'd12, 16'h0AAA);
    rdchk("R8 fall captured", 4'd13, 16'h0BBB);
    rdchk("R8 both on fall", 4'd14, 16'h0BBB);
    rdchk("R9 no flag when disabled", 4'd6, 16'h0050);
    wr(4'd6, 16'h007F); wr(4'd5, 16'h0538); wr(4'd2, 16'h0CCC);
    cap_in[0] = 1'b1; wait_n(4);
    rdchk("R8 code off", 4'd12, 16'h0AAA);
    rdchk("R8 off sets no flag", 4'd6, 16'h0000);
    cap_in[0] = 1'b0; wait_n(4);

    // R10: capture flag set in the same edge as its clear
    wr(4'd5, 16'h0539);
    cap_in[0] = 1'b1;
    wait_n(2);
    wr(4'd6, 16'h0010);
    rdchk("R10 set wins over clear", 4'd6, 16'h0010);
    rdchk("R8 capture of concurrent edge", 4'd12, 16'h0CCC);
    cap_in[0] = 1'b0; wait_n(4);
    wr(4'd6, 16'h007F); wr(4'd5, 16'h0000);

    // R3: event mode, prescaler bypassed
    wr(4'd1, 16'd7); wr(4'd2, 16'd0); wr(4'd0, 16'h0003);
    pulse_cnt(5); wait_n(4);
    rdchk("R3 rising edges counted", 4'd2, 16'd5);
    wr(4'd0, 16'h0007);
    pulse_cnt(3); wait_n(4);
    rdchk("R3 falling edges counted", 4'd2, 16'd8);
    wr(4'd0, 16'h0000);

    summary();
    $finish;
  end
endmodule